// File: doc/BRIEF.md
# Stop-Release Stabilization Timer

This block gates the core clock after a low-power stop state ends. When stop is entered, `clk_ready` drops and the block captures the timer source select bit. When stop is later released, the block either reports ready at once (bypass set) or holds `clk_ready` low until a fixed number of ticks have arrived from one of three counting sources. This gives the oscillator that was just restarted time to settle.

The counting source is picked from two values: the select bit captured at stop entry, and the speed mode captured at the release.

- **Select bit 1:** the raw sub-clock tick is counted, whatever the mode.
- **Select bit 0, low-speed mode:** the sub/16 tick is counted.
- **Select bit 0, any other mode:** the main/16 tick is counted.

With the default terminal count of 512, this works out to roughly 16 ms, 256 ms and 1 ms respectively, assuming an 8 MHz main clock and a 32 kHz sub clock. All sources reach the block as single-cycle enables in the system clock domain.

Top module: `wake_settle_timer`

## Requirements
- R1: After reset `clk_ready` is 1 and no count is in progress.
- R2: A cycle with `stop_enter` = 1 makes `clk_ready` 0 after that edge. This takes precedence over `stop_release` and over any tick arriving in the same cycle. The block stays halted, with ticks having no effect, until a later release.
- R3: A release while halted with `bypass` = 1 makes `clk_ready` 1 after that same edge, with no count.
- R4: With the captured select bit 0 and `speed_mode` at release equal to 2'b00 (high), 2'b01 (middle) or 2'b11 (reserved), only `tick_main16` is counted.
  - Ticks in the release cycle are not counted.
  - `clk_ready` becomes 1 after the edge that takes the TERM_COUNT-th counted tick.
- R5: With the captured select bit 0 and `speed_mode` = 2'b10 (low) at release, only `tick_sub16` is counted, with the same timing as R4.
- R6: With the captured select bit 1, only `tick_sub` is counted, with the same timing as R4, for every `speed_mode` value.
- R7: The select bit is captured only in a `stop_enter` cycle. Changes to `src_sel` while halted or counting have no effect on which source is counted.
- R8: Once 1, `clk_ready` stays 1 until the next `stop_enter`. A `stop_release` while running or counting is ignored.
- R9: A `stop_enter` during counting aborts the count and recaptures the select bit. The next release starts again from zero ticks on the newly selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_enter | input | 1 | One-cycle pulse: stop state entered |
| stop_release | input | 1 | One-cycle pulse: stop state released |
| src_sel | input | 1 | Timer source select bit (1 = raw sub clock), captured at stop entry |
| bypass | input | 1 | 1 = skip the stabilization delay at release |
| speed_mode | input | 2 | Active clock mode: 00 high, 01 middle, 10 low, 11 reserved |
| tick_main16 | input | 1 | Enable pulse at main clock / 16 |
| tick_sub16 | input | 1 | Enable pulse at sub clock / 16 |
| tick_sub | input | 1 | Enable pulse at the raw sub clock rate |
| clk_ready | output | 1 | 1 = core clock may run |

## Verification
The hardest situation to reach is an abort in the middle of a count followed by a fresh release. That release must start from zero on a different source. Only the timing of `clk_ready` shows it: a count that resumed, or that stayed on the old source, rises too early or never.

The stimulus reaches it in three steps:
1. Let three main/16 ticks land.
2. Re-enter stop with the select bit flipped and a main tick in the same cycle.
3. Release, feed only main ticks for longer than the terminal count, then switch to sub ticks and check that `clk_ready` rises exactly at the terminal count.

A swept set of tick phases and rates runs every select, mode and bypass combination, so counting the wrong source always shifts the rise cycle.

// File: rtl/settle_pkg.sv
package settle_pkg;
   typedef enum logic [1:0] {
      SPD_HIGH = 2'b00,
      SPD_MID  = 2'b01,
      SPD_LOW  = 2'b10,
      SPD_RSVD = 2'b11
   } speed_e;

   typedef enum logic [1:0] {
      PH_RUN    = 2'b00,
      PH_HALT   = 2'b01,
      PH_SETTLE = 2'b10
   } phase_e;
endpackage

// File: rtl/settle_src_mux.sv
module settle_src_mux (
   input  logic use_raw_sub,
   input  logic low_mode,
   input  logic tick_main16,
   input  logic tick_sub16,
   input  logic tick_sub,
   output logic tick_o
);
   always_comb begin
      if (use_raw_sub)
         tick_o = tick_sub;
      else if (low_mode)
         tick_o = tick_sub16;
      else
         tick_o = tick_main16;
   end
endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
   parameter int TERM_COUNT = 512,
   parameter bit DOWN_COUNT = 1'b0,
   localparam int CNT_W = (TERM_COUNT > 2) ? $clog2(TERM_COUNT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last_o
);
   logic [CNT_W-1:0] cnt_q;

   if (TERM_COUNT < 2) begin : g_bad_term
      $error("settle_counter: TERM_COUNT must be at least 2");
   end

   if (DOWN_COUNT) begin : g_down
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= CNT_W'(TERM_COUNT - 1);
         else if (clear)
            cnt_q <= CNT_W'(TERM_COUNT - 1);
         else if (step)
            cnt_q <= cnt_q - 1'b1;
      end
      assign last_o = (cnt_q == '0);
   end else begin : g_up
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clear)
            cnt_q <= '0;
         else if (step)
            cnt_q <= cnt_q + 1'b1;
      end
      assign last_o = (cnt_q == CNT_W'(TERM_COUNT - 1));
   end
endmodule

// File: rtl/wake_settle_timer.sv
module wake_settle_timer #(
   parameter int TERM_COUNT = 512,
   parameter bit DOWN_COUNT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_enter,
   input  logic       stop_release,
   input  logic       src_sel,
   input  logic       bypass,
   input  logic [1:0] speed_mode,
   input  logic       tick_main16,
   input  logic       tick_sub16,
   input  logic       tick_sub,
   output logic       clk_ready
);
   import settle_pkg::*;

   if (TERM_COUNT < 2) begin : g_bad_term
      $error("wake_settle_timer: TERM_COUNT must be at least 2");
   end

   phase_e phase_q, phase_d;
   logic   sel_q;
   logic   low_q;
   logic   halted, settling;
   logic   sel_tick;
   logic   cnt_clear, cnt_step, cnt_last;

   assign halted   = (phase_q == PH_HALT);
   assign settling = (phase_q == PH_SETTLE);

   settle_src_mux u_mux (
      .use_raw_sub (sel_q),
      .low_mode    (low_q),
      .tick_main16 (tick_main16),
      .tick_sub16  (tick_sub16),
      .tick_sub    (tick_sub),
      .tick_o      (sel_tick)
   );

   assign cnt_clear = halted && stop_release && !stop_enter;
   assign cnt_step  = settling && sel_tick && !stop_enter;

   settle_counter #(
      .TERM_COUNT (TERM_COUNT),
      .DOWN_COUNT (DOWN_COUNT)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cnt_clear),
      .step   (cnt_step),
      .last_o (cnt_last)
   );

   always_comb begin
      phase_d = phase_q;
      if (stop_enter) begin
         phase_d = PH_HALT;
      end else begin
         unique case (phase_q)
            PH_HALT:   if (stop_release) phase_d = bypass ? PH_RUN : PH_SETTLE;
            PH_SETTLE: if (cnt_step && cnt_last) phase_d = PH_RUN;
            default:   phase_d = phase_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         sel_q   <= 1'b0;
         low_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (stop_enter)
            sel_q <= src_sel;
         if (cnt_clear)
            low_q <= (speed_mode == SPD_LOW);
      end
   end

   assign clk_ready = (phase_q == PH_RUN);
endmodule

// File: rtl/settle_chk.sv
module settle_chk #(
   parameter int TERM_COUNT = 512
) (
   input logic clk,
   input logic rst_n,
   input logic stop_enter,
   input logic stop_release,
   input logic bypass,
   input logic clk_ready,
   input logic halted,
   input logic settling,
   input logic sel_tick,
   input logic sel_q
);
   localparam int CW = $clog2(TERM_COUNT + 1) + 1;
   logic [CW-1:0] seen_q;
   logic          take;

   assign take = settling && sel_tick && !stop_enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (halted && stop_release)
         seen_q <= '0;
      else if (take)
         seen_q <= seen_q + 1'b1;
   end

   // R2
   halt_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_enter |=> !clk_ready);

   // R3
   bypass_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && stop_release && bypass && !stop_enter) |=> clk_ready);

   // R8
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready && !stop_enter) |=> clk_ready);

   // R4
   terminal_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && seen_q == CW'(TERM_COUNT - 1)) |=> clk_ready);

   // R4
   no_early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (settling && !(take && seen_q == CW'(TERM_COUNT - 1))) |=> !clk_ready);

   // R7
   sel_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_enter |=> $stable(sel_q));
endmodule

bind wake_settle_timer settle_chk #(.TERM_COUNT(TERM_COUNT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stop_enter   (stop_enter),
   .stop_release (stop_release),
   .bypass       (bypass),
   .clk_ready    (clk_ready),
   .halted       (halted),
   .settling     (settling),
   .sel_tick     (sel_tick),
   .sel_q        (sel_q)
);

// File: tb/sim_wake_settle_timer.sv
`timescale 1ns/1ps
module sim_wake_settle_timer;
   localparam int TERM = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_enter = 1'b0, stop_release = 1'b0, src_sel = 1'b0, bypass = 1'b0;
   logic [1:0] speed_mode = 2'b00;
   logic       tick_main16 = 1'b0, tick_sub16 = 1'b0, tick_sub = 1'b0;
   logic       clk_ready;
   int         n_cmp = 0, n_bad = 0, cyc = 0;

   always #4 clk = ~clk;

   wake_settle_timer #(.TERM_COUNT(TERM)) u0 (
      .clk(clk), .rst_n(rst_n), .stop_enter(stop_enter), .stop_release(stop_release),
      .src_sel(src_sel), .bypass(bypass), .speed_mode(speed_mode),
      .tick_main16(tick_main16), .tick_sub16(tick_sub16), .tick_sub(tick_sub),
      .clk_ready(clk_ready)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R8 watchdog expired: cycles=%0d expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: clk_ready=%0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic ticks(input logic m, input logic s16, input logic s);
      tick_main16 = m; tick_sub16 = s16; tick_sub = s;
   endtask

   task automatic run_case(input logic sel, input logic [1:0] mode, input logic byp, input int ph);
      int n = 0;
      int which;
      logic t0, t1, t2, hit, exp;
      ticks(0, 0, 0);
      src_sel = sel; stop_enter = 1'b1;
      step();
      stop_enter = 1'b0;
      chk(clk_ready, 1'b0, "R2 entry");
      src_sel = ~sel;                       // R7: later change must not matter
      ticks(1, 1, 1);
      step(); chk(clk_ready, 1'b0, "R2 halted ticks");
      step(); chk(clk_ready, 1'b0, "R2 halted ticks");
      ticks(1, 1, 1);
      speed_mode = mode; bypass = byp; stop_release = 1'b1;
      step();
      stop_release = 1'b0; bypass = 1'b0;
      if (byp) begin
         chk(clk_ready, 1'b1, "R3 bypass");
      end else begin
         chk(clk_ready, 1'b0, "R4 release");
         which = sel ? 2 : ((mode == 2'b10) ? 1 : 0);
         for (int i = 0; i < 400; i++) begin
            t0 = ((i + ph) % 2) == 0;
            t1 = ((i + ph) % 3) == 1;
            t2 = ((i + 2 * ph) % 5) == 2;
            ticks(t0, t1, t2);
            hit = (which == 0) ? t0 : ((which == 1) ? t1 : t2);
            if (hit) n++;
            step();
            exp = (n >= TERM);
            if (which == 0)      chk(clk_ready, exp, "R4 main16 count");
            else if (which == 1) chk(clk_ready, exp, "R5 sub16 count");
            else                 chk(clk_ready, exp, "R6 R7 raw sub count");
            if (exp) break;
         end
      end
      ticks(1, 1, 1); stop_release = 1'b1;
      step();
      stop_release = 1'b0;
      chk(clk_ready, 1'b1, "R8 release ignored while running");
      ticks(0, 0, 0);
   endtask

   initial begin
      #3;
      rst_n = 1'b0;
      step();
      chk(clk_ready, 1'b1, "R1 reset value");
      rst_n = 1'b1;
      step();
      chk(clk_ready, 1'b1, "R1 after reset");

      for (int s = 0; s < 2; s++)
         for (int m = 0; m < 4; m++)
            for (int b = 0; b < 2; b++)
               for (int p = 0; p < 3; p++)
                  run_case(s[0], m[1:0], b[0], p);

      // R2: entry wins over a same-cycle release and ticks
      src_sel = 1'b1; stop_enter = 1'b1; stop_release = 1'b1; ticks(1, 1, 1);
      step();
      stop_enter = 1'b0; stop_release = 1'b0; src_sel = 1'b0;
      chk(clk_ready, 1'b0, "R2 priority over release");
      for (int i = 0; i < 3; i++) begin
         step(); chk(clk_ready, 1'b0, "R2 no count while halted");
      end
      ticks(0, 0, 0); speed_mode = 2'b00; stop_release = 1'b1;
      step();
      stop_release = 1'b0;
      ticks(0, 0, 1);
      for (int i = 1; i <= TERM; i++) begin
         step(); chk(clk_ready, (i >= TERM), "R6 R2 raw sub after priority entry");
      end
      ticks(0, 0, 0);

      // R9: abort mid-count, relatch to raw sub, restart from zero
      src_sel = 1'b0; stop_enter = 1'b1;
      step();
      stop_enter = 1'b0;
      speed_mode = 2'b00; stop_release = 1'b1;
      step();
      stop_release = 1'b0;
      ticks(1, 0, 0);
      for (int i = 0; i < 3; i++) begin
         step(); chk(clk_ready, 1'b0, "R9 partial count");
      end
      src_sel = 1'b1; stop_enter = 1'b1;
      step();
      stop_enter = 1'b0; src_sel = 1'b0;
      chk(clk_ready, 1'b0, "R9 abort");
      ticks(0, 0, 0); stop_release = 1'b1;
      step();
      stop_release = 1'b0;
      ticks(1, 1, 0);
      for (int i = 0; i < 2 * TERM; i++) begin
         step(); chk(clk_ready, 1'b0, "R9 old source ignored");
      end
      ticks(0, 0, 1);
      for (int i = 1; i <= TERM; i++) begin
         step(); chk(clk_ready, (i >= TERM), "R9 restart from zero");
      end
      ticks(0, 0, 0);
      step(); chk(clk_ready, 1'b1, "R8 hold");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule